// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block turns 32-bit virtual addresses into physical addresses by reading one entry from a page table that lives in external memory. The only translation state kept inside the unit is the table base address; every request therefore costs exactly one memory read of a table entry before the answer is known. The upper 20 address bits select the entry and the lower 12 bits pass through untouched as the offset inside a 4 KB page.

A client presents a virtual address with a read/write flag over a valid/ready handshake. The unit fetches the entry over a simple request/response read port and checks the present and permission bits. It then answers with a one-cycle done pulse that carries either a physical address or a fault code. The base register is loaded on a context switch to move the unit onto another process's table; such a load is taken only while the unit is idle.

Top module: `pt_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0 and `mem_rd_valid` is 0.
- R2: The entry is read at address `base + VA[31:12]*4` (modulo 2^32). This address stays on `mem_rd_addr`, with `mem_rd_valid` held high and the address unchanged, until `mem_rd_ready` is seen.
- R3: With no fault, `pa` equals entry bits 31:12 followed by `VA[11:0]`, and `fault` is 0 (none).
- R4: If entry bit 0 (present) is 0, `fault` is 1 (not-present) whatever the other bits hold, and `pa` is 0.
- R5: If the entry is present but lacks permission, `fault` is 2 (protection) and `pa` is 0. A write needs entry bit 2 set and a read needs entry bit 1 set. Fault code 3 never appears.
- R6: Entry bits 11:3 have no effect on `pa` or `fault`.
- R7: Each accepted request gives exactly one `done` pulse of one cycle. `req_ready` is 0 from the cycle after acceptance until after that pulse.
- R8: A base load (`base_we`) takes effect only when the unit is idle (`req_ready` high). A load while busy has no effect. A request accepted in the same cycle as a load uses the previous base.
- R9: Each translation issues exactly one accepted read on the memory port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_we | input | 1 | Load strobe for the table base |
| base_wdata | input | 32 | New table base value |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| mem_rd_valid | output | 1 | Entry read request valid |
| mem_rd_ready | input | 1 | Memory takes the read request |
| mem_rd_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 32 | Entry word |
| done | output | 1 | One-cycle result pulse |
| pa | output | 32 | Physical address (0 on fault) |
| fault | output | 2 | 0 none, 1 not-present, 2 protection |

## Verification
The bench sweeps the low 64 page numbers and the top 8 under two table bases, one of which makes the entry address wrap past 2^32. It uses both access kinds. Entry words are derived arithmetically from their address, so every combination of present, read and write bits meets both access kinds, and bits 11:3 carry changing junk. The sweep separates correct indexing, concatenation and fault priority from swapped or misdecoded bits. Runs are repeated with a stalling memory to show that the read request is held steady. Dedicated sequences load the base while busy and in the acceptance cycle, which tells a properly gated base register from one that updates at any time.

// File: rtl/pt_xlate_pkg.sv
// Shared types for the page table translator.
// Assumes: fault codes are carried as 2-bit values on the port.
package pt_xlate_pkg;

    typedef enum logic [1:0] {
        FLT_NONE       = 2'd0,
        FLT_NOTPRESENT = 2'd1,
        FLT_PROTECT    = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_RESP = 2'd3
    } walk_state_e;

endpackage

// File: rtl/pt_base_reg.sv
// Holds the page table base address of the running process.
// A load is taken only while the walker reports idle; loads while a
// translation is in flight are dropped.
// Assumes: synchronous active-low reset, reset value given by parameter.
module pt_base_reg #(
    parameter int          ADDR_W   = 32,
    parameter logic [31:0] BASE_RST = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_data,
    input  logic              idle,
    output logic [ADDR_W-1:0] base_q
);

    // Purpose: capture a new base only when no walk is running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= BASE_RST[ADDR_W-1:0];
        else if (load_en && idle)
            base_q <= load_data;
    end

    // A load while busy must leave the base untouched (R8).
    assert_busy_load_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !idle) |=> $stable(base_q));

endmodule

// File: rtl/pt_entry_check.sv
// Decodes one page table entry against the access kind.
// Gives the frame number and a fault code; not-present outranks a
// permission failure. Bits between the flags and the frame are ignored.
// Assumes: flag and frame positions fixed by parameters.
module pt_entry_check
    import pt_xlate_pkg::*;
#(
    parameter int ENTRY_W   = 32,
    parameter int FRAME_W   = 20,
    parameter int PRESENT_B = 0,
    parameter int RD_OK_B   = 1,
    parameter int WR_OK_B   = 2
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic               is_write,
    output fault_e             fault,
    output logic [FRAME_W-1:0] frame
);

    localparam int FRAME_LSB = ENTRY_W - FRAME_W;

    logic allowed;

    // Purpose: pick the permission bit matching the access kind.
    always_comb begin
        allowed = is_write ? entry[WR_OK_B] : entry[RD_OK_B];
    end

    // Purpose: classify the entry with not-present first.
    always_comb begin
        if (!entry[PRESENT_B])
            fault = FLT_NOTPRESENT;
        else if (!allowed)
            fault = FLT_PROTECT;
        else
            fault = FLT_NONE;
    end

    // Purpose: extract the frame number field.
    always_comb begin
        frame = entry[ENTRY_W-1:FRAME_LSB];
    end

endmodule

// File: rtl/pt_walk_ctrl.sv
// Sequences one translation: takes the request, issues a single entry
// read, waits for the entry, registers the checked result and raises a
// one-cycle done pulse.
// Assumes: memory returns exactly one response per accepted read.
module pt_walk_ctrl
    import pt_xlate_pkg::*;
#(
    parameter int VA_W     = 32,
    parameter int OFFSET_W = 12,
    parameter int ADDR_W   = 32,
    parameter int ENTRY_W  = 32,
    parameter int FRAME_W  = 20,
    parameter int ENT_SH   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  table_base,
    output logic               mem_rd_valid,
    input  logic               mem_rd_ready,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    input  logic               mem_rsp_valid,
    input  logic [ENTRY_W-1:0] mem_rsp_data,
    output logic [ENTRY_W-1:0] chk_entry,
    output logic               chk_write,
    input  fault_e             chk_fault,
    input  logic [FRAME_W-1:0] chk_frame,
    output logic               done,
    output logic [FRAME_W+OFFSET_W-1:0] pa,
    output logic [1:0]         fault
);

    localparam int VPN_W = VA_W - OFFSET_W;
    localparam int PA_W  = FRAME_W + OFFSET_W;

    walk_state_e           state_q;
    logic [OFFSET_W-1:0]   offset_q;
    logic                  write_q;
    logic [ADDR_W-1:0]     ent_addr_q;
    logic [ADDR_W-1:0]     ent_addr_d;
    logic [PA_W-1:0]       pa_q;
    logic [1:0]            fault_q;
    logic                  take_req;

    // Purpose: form the entry byte address from base and page number.
    always_comb begin
        ent_addr_d = table_base
                   + ({{(ADDR_W-VPN_W){1'b0}}, req_vaddr[VA_W-1:OFFSET_W]} << ENT_SH);
    end

    // Purpose: handshake decode for the request side.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        take_req  = req_valid && req_ready;
    end

    // Purpose: walk state sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (take_req)      state_q <= ST_REQ;
                ST_REQ:  if (mem_rd_ready)  state_q <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) state_q <= ST_RESP;
                ST_RESP:                    state_q <= ST_IDLE;
                default:                    state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: capture request fields and entry address on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset_q   <= '0;
            write_q    <= 1'b0;
            ent_addr_q <= '0;
        end else if (take_req) begin
            offset_q   <= req_vaddr[OFFSET_W-1:0];
            write_q    <= req_write;
            ent_addr_q <= ent_addr_d;
        end
    end

    // Purpose: register the checked result when the entry arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa_q    <= '0;
            fault_q <= 2'd0;
        end else if (state_q == ST_WAIT && mem_rsp_valid) begin
            fault_q <= chk_fault;
            pa_q    <= (chk_fault == FLT_NONE) ? {chk_frame, offset_q} : '0;
        end
    end

    // Purpose: drive the memory port, checker inputs and result outputs.
    always_comb begin
        mem_rd_valid = (state_q == ST_REQ);
        mem_rd_addr  = ent_addr_q;
        chk_entry    = mem_rsp_data;
        chk_write    = write_q;
        done         = (state_q == ST_RESP);
        pa           = pa_q;
        fault        = fault_q;
    end

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    assert_no_pa_on_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault != 2'd0) |-> (pa == '0));

    assert_code_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fault != 2'd3));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_single_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && mem_rd_ready) |=> !mem_rd_valid);

endmodule

// File: rtl/pt_xlate.sv
// Top of the single-level page table translator: base register, walk
// controller and entry checker.
// Assumes: 32-bit entries, one entry per page number, pages of
// 2**OFFSET_W bytes.
module pt_xlate
    import pt_xlate_pkg::*;
#(
    parameter int          VA_W     = 32,
    parameter int          OFFSET_W = 12,
    parameter int          ADDR_W   = 32,
    parameter int          ENTRY_W  = 32,
    parameter int          FRAME_W  = 20,
    parameter logic [31:0] BASE_RST = 32'h0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               base_we,
    input  logic [ADDR_W-1:0]  base_wdata,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic               req_write,
    output logic               mem_rd_valid,
    input  logic               mem_rd_ready,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    input  logic               mem_rsp_valid,
    input  logic [ENTRY_W-1:0] mem_rsp_data,
    output logic               done,
    output logic [FRAME_W+OFFSET_W-1:0] pa,
    output logic [1:0]         fault
);

    localparam int ENT_SH = $clog2(ENTRY_W / 8);

    logic [ADDR_W-1:0]  base_q;
    logic [ENTRY_W-1:0] chk_entry;
    logic               chk_write;
    fault_e             chk_fault;
    logic [FRAME_W-1:0] chk_frame;

    pt_base_reg #(
        .ADDR_W   (ADDR_W),
        .BASE_RST (BASE_RST)
    ) u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (base_we),
        .load_data (base_wdata),
        .idle      (req_ready),
        .base_q    (base_q)
    );

    pt_walk_ctrl #(
        .VA_W     (VA_W),
        .OFFSET_W (OFFSET_W),
        .ADDR_W   (ADDR_W),
        .ENTRY_W  (ENTRY_W),
        .FRAME_W  (FRAME_W),
        .ENT_SH   (ENT_SH)
    ) u_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_write     (req_write),
        .table_base    (base_q),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_ready  (mem_rd_ready),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .chk_entry     (chk_entry),
        .chk_write     (chk_write),
        .chk_fault     (chk_fault),
        .chk_frame     (chk_frame),
        .done          (done),
        .pa            (pa),
        .fault         (fault)
    );

    pt_entry_check #(
        .ENTRY_W (ENTRY_W),
        .FRAME_W (FRAME_W)
    ) u_check (
        .entry    (chk_entry),
        .is_write (chk_write),
        .fault    (chk_fault),
        .frame    (chk_frame)
    );

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !done && !mem_rd_valid));

endmodule

// File: tb/tb_pt_xlate.sv
module tb_pt_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        mem_rd_valid;
    logic        mem_rd_ready;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        done;
    logic [31:0] pa;
    logic [1:0]  fault;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    pt_xlate dut (
        .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .mem_rd_valid(mem_rd_valid),
        .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .pa(pa), .fault(fault)
    );

    // Entry content derived from its address; bits 11:3 carry junk.
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [29:0] idx;
        idx = a[31:2];
        return {idx[19:0] ^ 20'h5A3C1, idx[8:0] ^ 9'h1F3, idx[2:0] ^ idx[5:3]};
    endfunction

    // Memory model: optional ready stalls and a response delay.
    logic       stall_mode = 1'b0;
    logic [1:0] rdy_cnt;
    logic [1:0] pend_cnt;
    logic [31:0] pend_addr;
    logic [31:0] last_addr;
    int          hs_count;

    assign mem_rd_ready = stall_mode ? (rdy_cnt == 2'd3) : 1'b1;

    always @(posedge clk) begin
        if (!rst_n) begin
            rdy_cnt       <= '0;
            pend_cnt      <= '0;
            pend_addr     <= '0;
            last_addr     <= '0;
            hs_count      <= 0;
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
        end else begin
            rdy_cnt       <= rdy_cnt + 2'd1;
            mem_rsp_valid <= 1'b0;
            if (pend_cnt != 0) begin
                pend_cnt <= pend_cnt - 2'd1;
                if (pend_cnt == 2'd1) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= mem_word(pend_addr);
                end
            end
            if (mem_rd_valid && mem_rd_ready) begin
                pend_addr <= mem_rd_addr;
                last_addr <= mem_rd_addr;
                pend_cnt  <= stall_mode ? 2'd2 : 2'd1;
                hs_count  <= hs_count + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        finish_run();
    end

    task automatic load_base(input logic [31:0] v);
        @(negedge clk);
        base_we = 1'b1; base_wdata = v;
        @(negedge clk);
        base_we = 1'b0;
    endtask

    // One translation; busy_load pulses base_we during the walk,
    // same_load pulses it in the acceptance cycle.
    task automatic translate(input logic [31:0] tbase, input logic [31:0] va,
                             input bit wr, input bit busy_load,
                             input bit same_load, input logic [31:0] junk_base);
        logic [31:0] eaddr, w, exp_pa;
        logic [1:0]  exp_f;
        bit          perm;
        int          hs0, n;
        eaddr = tbase + {10'd0, va[31:12], 2'b00};
        w     = mem_word(eaddr);
        perm  = wr ? w[2] : w[1];
        exp_f = !w[0] ? 2'd1 : (!perm ? 2'd2 : 2'd0);
        exp_pa = (exp_f == 2'd0) ? {w[31:12], va[11:0]} : 32'h0;
        @(negedge clk);
        hs0 = hs_count;
        req_valid = 1'b1; req_vaddr = va; req_write = wr;
        if (same_load) begin base_we = 1'b1; base_wdata = junk_base; end
        @(negedge clk);
        req_valid = 1'b0;
        base_we = 1'b0;
        chk(req_ready == 1'b0, "R7 busy", {31'd0, req_ready}, 32'd0);
        if (busy_load) begin base_we = 1'b1; base_wdata = junk_base; end
        n = 0;
        while (!done && n < 100) begin
            @(negedge clk);
            base_we = 1'b0;
            n++;
        end
        base_we = 1'b0;
        chk(done == 1'b1, "R7 done", {31'd0, done}, 32'd1);
        chk(last_addr == eaddr, "R2 entry addr", last_addr, eaddr);
        chk(fault == exp_f, "R3/R4/R5 fault", {30'd0, fault}, {30'd0, exp_f});
        chk(pa == exp_pa, "R3/R6 pa", pa, exp_pa);
        chk(hs_count - hs0 == 1, "R9 reads", hs_count - hs0, 32'd1);
        @(negedge clk);
        chk(done == 1'b0, "R7 pulse", {31'd0, done}, 32'd0);
    endtask

    initial begin
        logic [31:0] bases [2];
        bases[0] = 32'h0001_0000;
        bases[1] = 32'hFFFF_FF00;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", {31'd0, req_ready}, 32'd1);
        chk(done == 1'b0, "R1 done", {31'd0, done}, 32'd0);
        chk(mem_rd_valid == 1'b0, "R1 memvalid", {31'd0, mem_rd_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && !done && !mem_rd_valid, "R1 after reset",
            {29'd0, req_ready, done, mem_rd_valid}, 32'h4);

        // Sweep: R2 R3 R4 R5 R6 R9 over both bases and both stall modes.
        for (int b = 0; b < 2; b++) begin
            load_base(bases[b]);
            stall_mode = (b == 1);
            for (int v = 0; v < 72; v++) begin
                logic [19:0] vpn;
                logic [31:0] va;
                vpn = (v < 64) ? 20'(v) : 20'hFFFFF - 20'(v - 64);
                va  = {vpn, 12'((v * 37) % 4096)};
                for (int wr = 0; wr < 2; wr++)
                    translate(bases[b], va, wr[0], 1'b0, 1'b0, 32'h0);
            end
        end

        // R8: load while busy is dropped, old base still used afterwards.
        stall_mode = 1'b1;
        load_base(32'h0002_0000);
        translate(32'h0002_0000, 32'h0000_5123, 1'b0, 1'b1, 1'b0, 32'h0777_0000);
        translate(32'h0002_0000, 32'h0000_6456, 1'b1, 1'b0, 1'b0, 32'h0);
        // R8: load in the acceptance cycle, that request uses the old base.
        translate(32'h0002_0000, 32'h0000_7789, 1'b0, 1'b0, 1'b1, 32'h0003_0000);
        translate(32'h0003_0000, 32'h0000_7789, 1'b0, 1'b0, 1'b0, 32'h0);
        // R8: idle load switches to another process table.
        load_base(32'h0004_0400);
        translate(32'h0004_0400, 32'h0001_2ABC, 1'b1, 1'b0, 1'b0, 32'h0);

        finish_run();
    end

endmodule